// File: doc/BRIEF.md
# DRBG Generate Request Sequencer

This block sits between a register write port and the cipher core of a deterministic random bit generator. It decides when the core runs and in what order. Random output is produced only after software asks for a number of 128-bit blocks. For each request the sequencer runs one key/V state update, then the requested blocks one at a time, then a second state update. Each operation goes to an abstract cipher port that has a valid/ready request side and a one-cycle response pulse.

Finished blocks wait in a small buffer and move one at a time into an output data register. Software sees that register through a READY flag and releases it with an acknowledge write. When the buffer fills, generation pauses, and it resumes by itself as software drains data. A data-available interrupt can be held back until a programmed number of words is waiting. An optional secure-read mode hides the data register until a gate is opened, and the gate closes again after a programmed time or on acknowledge. Reseed activity and health-test readiness arrive as status inputs.

Top module: `drbg_gen_seq`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next state has `ready`, `irq`, `busy` and `err` at 0, the buffer empty, no cipher request pending and the hold latch clear.
- R2: A write with `wr_sel`=0 (control) carrying bit 16 = 1 and bit 17 = 0 starts a request for the block count in bits 31-20. The request is accepted only when the block is idle, `drbg_enable`=1, `reseed_active`=0 and `test_ready`=1. An accepted request issues exactly one update operation (`cph_req_update`=1), then N block operations (`cph_req_update`=0), then one update operation. A count of 0 issues the two updates only.
- R3: A control write with bit 17 = 1 and bit 16 = 1 records the count without starting. A later control write with bit 17 = 0 launches the recorded count, and is subject to the acceptance rule of R2.
- R4: No block operation is issued while the buffer (DEPTH words) is full. With no reads, at most DEPTH+1 blocks of a request are produced. Generation continues without further writes once words are read out.
- R5: Blocks appear on `rd_data` in the order the cipher returned them.
- R6: `ready` is 1 while the output register holds an unread word. A write with `wr_sel`=2 and bit 0 = 1 consumes that word, and the next buffered word loads on the same edge. `ready` never falls except on such a write or on reset.
- R7: A write with `wr_sel`=1 sets the threshold enable (bit 31) and the 7-bit threshold (bits 30-24). `irq` = `ready` AND (threshold disabled OR words held, output register plus buffer, >= threshold).
- R8: A launch that is not accepted under R2 issues no cipher operation and sets `err`, which stays at 1 until reset.
- R9: Bits 15-12 of the `wr_sel`=1 write hold the read timeout T. When T is non-zero, `rd_data` reads as 0 unless the gate is open. The gate opens on a `wr_sel`=3 write whose bits 15-0 equal OPEN_KEY, or on a `wr_sel`=2 write with bit 12 = 1. A `wr_sel`=3 write with any other value leaves it closed.
- R10: An opened gate stays open for exactly T*16 clock cycles and then closes. An acknowledge write (R6) closes it at once.
- R11: With `drbg_enable`=1 and no accepted request, the cipher port stays quiet.
- R12: `busy` is 1 from the edge that accepts a request until the response of its closing update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| drbg_enable | input | 1 | Generator enabled |
| reseed_active | input | 1 | Reseed in progress, blocks new requests |
| test_ready | input | 1 | Health tests ready |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 config, 2 acknowledge, 3 gate |
| wr_data | input | 32 | Register write data |
| rd_data | output | BLK_W | Output data register, masked by the read gate |
| ready | output | 1 | Output register holds a word |
| irq | output | 1 | Data-available interrupt |
| busy | output | 1 | Request in progress |
| err | output | 1 | Sticky rejected-request flag |
| cph_req_valid | output | 1 | Cipher operation request |
| cph_req_update | output | 1 | 1 = key/V update, 0 = generate one block |
| cph_req_ready | input | 1 | Cipher accepts the request |
| cph_rsp_valid | input | 1 | One-cycle completion pulse |
| cph_rsp_data | input | BLK_W | Block produced by a generate operation |

## Verification
The bench builds the block with DEPTH=3, so at most four words can sit unread. Sweeping block counts from 0 to 8 therefore covers requests that fit, requests that exactly fill the buffer and requests that stall and resume. With that small depth, every threshold value from 0 to 5 can be tried against a known fill level. A read timeout of 2 gives a 32-cycle gate window, short enough to check its first closed cycle precisely.

// File: rtl/drbg_gen_pkg.sv
// Package drbg_gen_pkg
// Shared register selects, field positions and sequencer states for the
// DRBG generate request sequencer. Field positions are fixed by the
// software-visible register layout.
package drbg_gen_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_CFG  = 2'd1,
        SEL_ACK  = 2'd2,
        SEL_GATE = 2'd3
    } reg_sel_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE_REQ,
        ST_PRE_WAIT,
        ST_BLK_REQ,
        ST_BLK_WAIT,
        ST_POST_REQ,
        ST_POST_WAIT
    } seq_state_e;

    localparam int CNT_LSB      = 20;
    localparam int CNT_W        = 12;
    localparam int STROBE_BIT   = 16;
    localparam int HOLD_BIT     = 17;
    localparam int THR_EN_BIT   = 31;
    localparam int THR_LSB      = 24;
    localparam int THR_W        = 7;
    localparam int TMO_LSB      = 12;
    localparam int TMO_W        = 4;
    localparam int ACK_BIT      = 0;
    localparam int OPEN_ALT_BIT = 12;
    localparam int KEY_W        = 16;

endpackage

// File: rtl/drbg_blk_fifo.sv
// Module drbg_blk_fifo
// Circular buffer of generated blocks. Assumes the writer never pushes when
// full and the reader never pops when empty; the fill count is exported so
// the sequencer can throttle and the interrupt logic can compare levels.
module drbg_blk_fifo #(
    parameter int W      = 128,
    parameter int DEPTH  = 4,
    localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  pop_data,
    output logic [CW-1:0] fill,
    output logic          full,
    output logic          empty
);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic [CW-1:0] count;

    // Advance a pointer with wrap at DEPTH (DEPTH need not be a power of two).
    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    // Storage write; contents need no reset since count guards reads.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            count <= count + CW'(push) - CW'(pop);
        end
    end

    assign pop_data = mem[rd_ptr];
    assign fill     = count;
    assign full     = (count == CW'(DEPTH));
    assign empty    = (count == '0);

endmodule

// File: rtl/drbg_seq_fsm.sv
// Module drbg_seq_fsm
// Runs one accepted request: opening state update, N block generations,
// closing state update. Assumes start is only raised while idle, that the
// cipher has at most one operation outstanding, and that space_ok only
// drops through this module's own pushes.
module drbg_seq_fsm
    import drbg_gen_pkg::*;
#(
    parameter int N_W = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [N_W-1:0] start_cnt,
    input  logic           space_ok,
    input  logic           req_ready,
    input  logic           rsp_valid,
    output logic           req_valid,
    output logic           req_update,
    output logic           push,
    output logic           busy
);

    seq_state_e     state;
    seq_state_e     state_nx;
    logic [N_W-1:0] remaining;

    // Next-state decode of the request sequence.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (start) state_nx = ST_PRE_REQ;
            ST_PRE_REQ:   if (req_ready) state_nx = ST_PRE_WAIT;
            ST_PRE_WAIT:  if (rsp_valid) state_nx = (remaining == '0) ? ST_POST_REQ : ST_BLK_REQ;
            ST_BLK_REQ:   if (space_ok && req_ready) state_nx = ST_BLK_WAIT;
            ST_BLK_WAIT:  if (rsp_valid) state_nx = (remaining == N_W'(1)) ? ST_POST_REQ : ST_BLK_REQ;
            ST_POST_REQ:  if (req_ready) state_nx = ST_POST_WAIT;
            ST_POST_WAIT: if (rsp_valid) state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // State register and remaining-block counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            remaining <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && start) begin
                remaining <= start_cnt;
            end else if (push) begin
                remaining <= remaining - N_W'(1);
            end
        end
    end

    // Cipher request and buffer write decode.
    always_comb begin
        req_valid  = 1'b0;
        req_update = 1'b0;
        unique case (state)
            ST_PRE_REQ, ST_POST_REQ: begin
                req_valid  = 1'b1;
                req_update = 1'b1;
            end
            ST_BLK_REQ: req_valid = space_ok;
            default: ;
        endcase
    end

    assign push = (state == ST_BLK_WAIT) && rsp_valid;
    assign busy = (state != ST_IDLE);

endmodule

// File: rtl/drbg_read_gate.sv
// Module drbg_read_gate
// Secure-read window. Opening loads timeout * 2^TICK_SHIFT cycles; the window
// closes when the count runs out or on a close request (close wins over open).
// Assumes the caller suppresses data when the gate is shut.
module drbg_read_gate #(
    parameter int TMO_W      = 4,
    parameter int TICK_SHIFT = 4,
    localparam int TW        = TMO_W + TICK_SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TMO_W-1:0] tmo,
    input  logic             open_req,
    input  logic             close_req,
    output logic             gate_open
);

    logic [TW-1:0] left;

    // Window state and countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_open <= 1'b0;
            left      <= '0;
        end else if (close_req) begin
            gate_open <= 1'b0;
            left      <= '0;
        end else if (open_req && tmo != '0) begin
            gate_open <= 1'b1;
            left      <= {tmo, {TICK_SHIFT{1'b0}}};
        end else if (gate_open) begin
            if (left == TW'(1)) begin
                gate_open <= 1'b0;
            end
            left <= left - TW'(1);
        end
    end

endmodule

// File: rtl/drbg_gen_seq.sv
// Module drbg_gen_seq (top)
// Decodes register writes into generate requests, runs the request
// sequencer, buffers blocks into a READY/acknowledge output register, and
// drives the threshold interrupt and the secure-read gate. Assumes the
// cipher returns exactly one response pulse per accepted request.
module drbg_gen_seq
    import drbg_gen_pkg::*;
#(
    parameter int          BLK_W      = 128,
    parameter int          DEPTH      = 4,
    parameter int          TICK_SHIFT = 4,
    parameter logic [15:0] OPEN_KEY   = 16'hC3A5,
    localparam int         FILL_W     = $clog2(DEPTH + 1),
    localparam int         LVL_W      = ((FILL_W + 1) > THR_W) ? (FILL_W + 1) : THR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             drbg_enable,
    input  logic             reseed_active,
    input  logic             test_ready,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [31:0]      wr_data,
    output logic [BLK_W-1:0] rd_data,
    output logic             ready,
    output logic             irq,
    output logic             busy,
    output logic             err,
    output logic             cph_req_valid,
    output logic             cph_req_update,
    input  logic             cph_req_ready,
    input  logic             cph_rsp_valid,
    input  logic [BLK_W-1:0] cph_rsp_data
);

    logic              ctrl_wr, cfg_wr, ack_sel_wr, gate_wr, ack_wr;
    logic              hold_pend;
    logic [CNT_W-1:0]  pend_cnt;
    logic              launch, can_start, start;
    logic [CNT_W-1:0]  launch_cnt;
    logic              thr_en;
    logic [THR_W-1:0]  thr_val;
    logic [TMO_W-1:0]  tmo_val;
    logic              push, pop;
    logic [BLK_W-1:0]  pop_data;
    logic [FILL_W-1:0] fifo_fill;
    logic              fifo_full, fifo_empty;
    logic [BLK_W-1:0]  data_reg;
    logic              gate_open, open_req, secure;
    logic [LVL_W-1:0]  level;

    // Register write decode.
    always_comb begin
        ctrl_wr    = wr_en && (wr_sel == SEL_CTRL);
        cfg_wr     = wr_en && (wr_sel == SEL_CFG);
        ack_sel_wr = wr_en && (wr_sel == SEL_ACK);
        gate_wr    = wr_en && (wr_sel == SEL_GATE);
        ack_wr     = ack_sel_wr && wr_data[ACK_BIT];
    end

    // Request launch and acceptance decision.
    always_comb begin
        launch     = ctrl_wr && !wr_data[HOLD_BIT] && (wr_data[STROBE_BIT] || hold_pend);
        launch_cnt = wr_data[STROBE_BIT] ? wr_data[CNT_LSB +: CNT_W] : pend_cnt;
        can_start  = drbg_enable && !reseed_active && test_ready && !busy;
        start      = launch && can_start;
    end

    // Hold latch for a partially written request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_pend <= 1'b0;
            pend_cnt  <= '0;
        end else if (ctrl_wr && wr_data[HOLD_BIT] && wr_data[STROBE_BIT]) begin
            hold_pend <= 1'b1;
            pend_cnt  <= wr_data[CNT_LSB +: CNT_W];
        end else if (launch) begin
            hold_pend <= 1'b0;
        end
    end

    // Sticky error for rejected launches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err <= 1'b0;
        end else if (launch && !can_start) begin
            err <= 1'b1;
        end
    end

    // Configuration register: threshold and read timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_en  <= 1'b0;
            thr_val <= '0;
            tmo_val <= '0;
        end else if (cfg_wr) begin
            thr_en  <= wr_data[THR_EN_BIT];
            thr_val <= wr_data[THR_LSB +: THR_W];
            tmo_val <= wr_data[TMO_LSB +: TMO_W];
        end
    end

    drbg_seq_fsm #(
        .N_W (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_cnt  (launch_cnt),
        .space_ok   (!fifo_full),
        .req_ready  (cph_req_ready),
        .rsp_valid  (cph_rsp_valid),
        .req_valid  (cph_req_valid),
        .req_update (cph_req_update),
        .push       (push),
        .busy       (busy)
    );

    drbg_blk_fifo #(
        .W     (BLK_W),
        .DEPTH (DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (cph_rsp_data),
        .pop       (pop),
        .pop_data  (pop_data),
        .fill      (fifo_fill),
        .full      (fifo_full),
        .empty     (fifo_empty)
    );

    assign pop = !fifo_empty && (!ready || ack_wr);

    // Output data register with READY/acknowledge handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready    <= 1'b0;
            data_reg <= '0;
        end else if (pop) begin
            ready    <= 1'b1;
            data_reg <= pop_data;
        end else if (ack_wr) begin
            ready    <= 1'b0;
        end
    end

    // Threshold interrupt on words held in output register plus buffer.
    always_comb begin
        level = LVL_W'(fifo_fill) + LVL_W'(ready);
        irq   = ready && (!thr_en || level >= LVL_W'(thr_val));
    end

    assign open_req = (gate_wr && wr_data[KEY_W-1:0] == OPEN_KEY)
                    || (ack_sel_wr && wr_data[OPEN_ALT_BIT]);

    drbg_read_gate #(
        .TMO_W      (TMO_W),
        .TICK_SHIFT (TICK_SHIFT)
    ) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .tmo       (tmo_val),
        .open_req  (open_req),
        .close_req (ack_wr),
        .gate_open (gate_open)
    );

    // Data masking in secure-read mode.
    always_comb begin
        secure  = (tmo_val != '0);
        rd_data = (!secure || gate_open) ? data_reg : '0;
    end

endmodule

// File: rtl/drbg_gen_seq_chk.sv
// Module drbg_gen_seq_chk
// Property checker for drbg_gen_seq, attached by bind. Observes ports and
// the buffer fill and acknowledge decode of the top.
module drbg_gen_seq_chk #(
    parameter int DEPTH  = 4,
    parameter int FILL_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ready,
    input logic              irq,
    input logic              busy,
    input logic              err,
    input logic              cph_req_valid,
    input logic              cph_req_ready,
    input logic              cph_req_update,
    input logic              ack_wr,
    input logic [FILL_W-1:0] fill
);

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (!ready && !irq && !busy && !err));

    assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cph_req_valid && !cph_req_ready) |=> (cph_req_valid && $stable(cph_req_update)));

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= FILL_W'(DEPTH));

    assert_ready_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ready) && $past(rst_n)) |-> $past(ack_wr));

    assert_irq_needs_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ready);

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !cph_req_valid);

endmodule

bind drbg_gen_seq drbg_gen_seq_chk #(
    .DEPTH  (DEPTH),
    .FILL_W (FILL_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .ready          (ready),
    .irq            (irq),
    .busy           (busy),
    .err            (err),
    .cph_req_valid  (cph_req_valid),
    .cph_req_ready  (cph_req_ready),
    .cph_req_update (cph_req_update),
    .ack_wr         (ack_wr),
    .fill           (fifo_fill)
);

// File: tb/drbg_gen_seq_tb.sv
// Bench for drbg_gen_seq: sweeps block counts and thresholds on a small
// buffer, models the cipher with a fixed latency and stalling ready.
module drbg_gen_seq_tb;

    localparam int          CLK_PERIOD = 10;
    localparam int          BLK_W      = 128;
    localparam int          DEPTH      = 3;
    localparam logic [15:0] KEY        = 16'hC3A5;
    localparam int          CAP        = DEPTH + 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             drbg_enable = 1'b1;
    logic             reseed_active = 1'b0;
    logic             test_ready = 1'b1;
    logic             wr_en = 1'b0;
    logic [1:0]       wr_sel = 2'd0;
    logic [31:0]      wr_data = '0;
    logic [BLK_W-1:0] rd_data;
    logic             ready, irq, busy, err;
    logic             cph_req_valid, cph_req_update, cph_req_ready;
    logic             cph_rsp_valid = 1'b0;
    logic [BLK_W-1:0] cph_rsp_data = '0;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int stall_cnt = 0;
    logic m_pend = 1'b0;
    int m_lat = 0;
    int blk_seq = 0;
    int n_upd = 0;
    int n_blk = 0;
    logic in_gen = 1'b0;
    int order_err = 0;
    int next_exp = 1;
    bit secure_mode = 0;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    drbg_gen_seq #(
        .BLK_W    (BLK_W),
        .DEPTH    (DEPTH),
        .OPEN_KEY (KEY)
    ) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .drbg_enable    (drbg_enable),
        .reseed_active  (reseed_active),
        .test_ready     (test_ready),
        .wr_en          (wr_en),
        .wr_sel         (wr_sel),
        .wr_data        (wr_data),
        .rd_data        (rd_data),
        .ready          (ready),
        .irq            (irq),
        .busy           (busy),
        .err            (err),
        .cph_req_valid  (cph_req_valid),
        .cph_req_update (cph_req_update),
        .cph_req_ready  (cph_req_ready),
        .cph_rsp_valid  (cph_rsp_valid),
        .cph_rsp_data   (cph_rsp_data)
    );

    assign cph_req_ready = (stall_cnt % 3) != 2;

    // Cipher model: latency 3, logs operation order, numbers each block.
    always @(posedge clk) begin
        stall_cnt     <= stall_cnt + 1;
        cph_rsp_valid <= 1'b0;
        if (m_pend) begin
            if (m_lat == 0) begin
                cph_rsp_valid <= 1'b1;
                m_pend        <= 1'b0;
            end else begin
                m_lat <= m_lat - 1;
            end
        end
        if (cph_req_valid && cph_req_ready) begin
            m_pend <= 1'b1;
            m_lat  <= 2;
            if (cph_req_update) begin
                n_upd  <= n_upd + 1;
                in_gen <= !in_gen;
            end else begin
                if (!in_gen) order_err <= order_err + 1;
                n_blk        <= n_blk + 1;
                blk_seq      <= blk_seq + 1;
                cph_rsp_data <= {4{32'(blk_seq + 1)}};
            end
        end
    end

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<%0d", cyc, 150000);
            summary();
        end
    end

    task automatic check(input bit ok, input string tag, input logic [BLK_W-1:0] act,
                         input logic [BLK_W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    function automatic logic [31:0] ctrl_word(input int n, input bit strobe, input bit hold);
        return (32'(n) << 20) | (32'(hold) << 17) | (32'(strobe) << 16);
    endfunction

    function automatic logic [31:0] cfg_word(input bit en, input int thr, input int tmo);
        return (32'(en) << 31) | ((32'(thr) & 32'h7F) << 24) | ((32'(tmo) & 32'hF) << 12);
    endfunction

    task automatic wait_ready();
        int k = 0;
        while (!ready && k < 3000) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic wait_idle();
        int k = 0;
        while (busy && k < 3000) begin
            @(negedge clk);
            k++;
        end
    endtask

    // R5/R6: read one word, compare with the next expected block, acknowledge.
    task automatic read_one();
        logic [BLK_W-1:0] exp;
        wait_ready();
        exp = {4{32'(next_exp)}};
        if (secure_mode) wr(2'd3, {16'h0, KEY});
        check(ready == 1'b1, "R6 ready before read", BLK_W'(ready), 1);
        check(rd_data == exp, "R5 block order", rd_data, exp);
        next_exp++;
        wr(2'd2, 32'h1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(!ready && !irq && !busy && !err && !cph_req_valid, "R1 reset state",
              BLK_W'({ready, irq, busy, err, cph_req_valid}), 0);
        rst_n = 1'b1;
    endtask

    initial begin
        int b_upd, b_blk, exp_cap;
        repeat (3) @(negedge clk);
        check(!ready && !irq && !busy && !err && !cph_req_valid, "R1 reset state",
              BLK_W'({ready, irq, busy, err, cph_req_valid}), 0);
        rst_n = 1'b1;
        wr(2'd1, cfg_word(0, 0, 0));

        // R2/R4/R12 sweep over block counts, including ones beyond capacity.
        for (int n = 0; n <= 8; n++) begin
            b_upd = n_upd;
            b_blk = n_blk;
            wr(2'd0, ctrl_word(n, 1, 0));
            check(busy == 1'b1, "R12 busy after accept", BLK_W'(busy), 1);
            repeat (150) @(negedge clk);
            exp_cap = (n < CAP) ? n : CAP;
            check(n_blk - b_blk == exp_cap, "R4 blocks produced without reads",
                  BLK_W'(n_blk - b_blk), BLK_W'(exp_cap));
            check(irq == (n > 0), "R7 irq with threshold off", BLK_W'(irq), BLK_W'(n > 0));
            for (int i = 0; i < n; i++) read_one();
            wait_idle();
            check(busy == 1'b0, "R12 busy cleared", BLK_W'(busy), 0);
            check(n_upd - b_upd == 2, "R2 two updates", BLK_W'(n_upd - b_upd), 2);
            check(n_blk - b_blk == n, "R2 block count", BLK_W'(n_blk - b_blk), BLK_W'(n));
            check(order_err == 0, "R2 update bracketing", BLK_W'(order_err), 0);
            check(err == 1'b0, "R8 no error on valid request", BLK_W'(err), 0);
        end

        // R11: idle with enable set produces nothing.
        b_blk = n_blk;
        b_upd = n_upd;
        repeat (60) @(negedge clk);
        check(n_blk == b_blk && n_upd == b_upd, "R11 no spontaneous generation",
              BLK_W'(n_blk - b_blk), 0);

        // R3: held request does not start, release launches recorded count.
        b_blk = n_blk;
        wr(2'd0, ctrl_word(2, 1, 1));
        repeat (30) @(negedge clk);
        check(!busy && n_blk == b_blk, "R3 held request idle", BLK_W'(n_blk - b_blk), 0);
        wr(2'd0, ctrl_word(0, 0, 0));
        read_one();
        read_one();
        wait_idle();
        check(n_blk - b_blk == 2, "R3 released count", BLK_W'(n_blk - b_blk), 2);

        // R7: threshold sweep with two words held.
        for (int t = 0; t <= 5; t++) begin
            wr(2'd1, cfg_word(1, t, 0));
            wr(2'd0, ctrl_word(2, 1, 0));
            repeat (100) @(negedge clk);
            check(irq == (2 >= t), "R7 threshold level", BLK_W'(irq), BLK_W'(2 >= t));
            read_one();
            check(irq == (1 >= t), "R7 threshold after one read", BLK_W'(irq), BLK_W'(1 >= t));
            read_one();
            wait_idle();
        end
        wr(2'd1, cfg_word(0, 0, 0));

        // R9/R10: secure gate with T=2 (32 cycles).
        wr(2'd1, cfg_word(0, 0, 2));
        wr(2'd0, ctrl_word(2, 1, 0));
        wait_ready();
        @(negedge clk);
        check(rd_data == '0, "R9 masked while closed", rd_data, 0);
        wr(2'd3, 32'h0000_1234);
        check(rd_data == '0, "R9 wrong key keeps gate shut", rd_data, 0);
        wr(2'd3, {16'h0, KEY});
        repeat (31) @(negedge clk);
        check(rd_data == {4{32'(next_exp)}}, "R10 open for full window", rd_data,
              {4{32'(next_exp)}});
        @(negedge clk);
        check(rd_data == '0, "R10 closed after timeout", rd_data, 0);
        wr(2'd2, 32'h0000_1000);
        check(rd_data == {4{32'(next_exp)}}, "R9 alternate open bit", rd_data,
              {4{32'(next_exp)}});
        next_exp++;
        wr(2'd2, 32'h1);
        wait_ready();
        @(negedge clk);
        check(rd_data == '0, "R10 acknowledge closes gate", rd_data, 0);
        secure_mode = 1;
        read_one();
        secure_mode = 0;
        wait_idle();
        wr(2'd1, cfg_word(0, 0, 0));

        // R8: request while busy is ignored and flags error.
        b_blk = n_blk;
        wr(2'd0, ctrl_word(6, 1, 0));
        repeat (20) @(negedge clk);
        wr(2'd0, ctrl_word(3, 1, 0));
        check(err == 1'b1, "R8 busy reject sets err", BLK_W'(err), 1);
        for (int i = 0; i < 6; i++) read_one();
        wait_idle();
        repeat (40) @(negedge clk);
        check(n_blk - b_blk == 6, "R8 busy reject ignored", BLK_W'(n_blk - b_blk), 6);
        check(err == 1'b1, "R8 err sticky", BLK_W'(err), 1);
        do_reset();

        // R2/R8: each status input alone blocks acceptance.
        for (int c = 0; c < 3; c++) begin
            drbg_enable   = (c != 0);
            test_ready    = (c != 1);
            reseed_active = (c == 2);
            b_upd = n_upd;
            wr(2'd0, ctrl_word(1, 1, 0));
            repeat (20) @(negedge clk);
            check(err == 1'b1 && !busy, "R8 status reject flags err", BLK_W'(err), 1);
            check(n_upd == b_upd, "R2 no operation when not ready", BLK_W'(n_upd - b_upd), 0);
            drbg_enable   = 1'b1;
            test_ready    = 1'b1;
            reseed_active = 1'b0;
            do_reset();
        end

        summary();
    end

endmodule